// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block sits between a UART's transmit and receive engines and the rest of the chip. It holds the status flags that those engines raise: transmit buffer empty, receive buffer full, three kinds of receive error, and a change on clear-to-send. It turns these flags into four level interrupt lines (transmit, receive, receive error, flow control) and two one-cycle DMA request strobes. Each interrupt line is gated by its own enable bit.

Software reaches the block through a small register bus with four addresses. Address 0 is the control register, address 1 is the status register, address 2 is the transmit buffer (write only) and address 3 is the receive buffer (read only). Every flag is cleared by one particular access to these registers.

Turning on DMA for a direction does two things. It masks that direction's interrupt, whatever the enable bit holds. It also makes the block issue a request pulse each time that direction's flag rises. The serial shifters, the baud generator and the DMA engine are outside this block.

Top module: `uart_irq_dma_ctl`

## Requirements
- R1: After reset, the transmit-empty flag is 1 and every other flag and every enable bit is 0. All interrupt and DMA outputs are low. A status read returns 0x10 and a control read returns 0x00.
- R2: `txIrq` is high exactly when the transmit-empty flag is set, the transmit enable (control bit 0) is set and transmit DMA (control bit 4) is clear. A write to address 2 pulses `txLoad` with `txByte` equal to the written data in the same cycle, and it clears the flag at the next edge.
- R3: `rxIrq` is high exactly when the receive-full flag is set, the receive enable (control bit 1) is set and receive DMA (control bit 5) is clear. A read of address 3 returns `rxByte` and clears the flag at the next edge.
- R4: The status register holds overrun in bit 0, parity in bit 1, framing in bit 2 and their OR in bit 3. It also holds transmit-empty in bit 4, receive-full in bit 5 and cts-changed in bit 6. `errIrq` is high when bit 3 and the error enable (control bit 2) are both set. A status read clears all three error bits together.
- R5: `fcIrq` is high when the cts-changed flag and the flow control enable (control bit 3) are both set. A control read returns the enables in bits 5:0 and cts-changed in bit 7, and it clears cts-changed.
- R6: While transmit DMA is on, a rise of the transmit-empty flag produces a one-cycle `txDmaReq` pulse, and `txIrq` stays low.
- R7: While receive DMA is on, a rise of the receive-full flag produces a one-cycle `rxDmaReq` pulse and `rxIrq` stays low. `errIrq` keeps working normally.
- R8: Transmit DMA and receive DMA can be on at the same time. Flags that rise in the same cycle give both pulses in the same cycle.
- R9: If a flag's set event and its clearing access fall in the same cycle, the flag ends up set.
- R10: Clearing an enable bit drops its interrupt at the next edge. Writes to addresses 1 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects apply) |
| addr | input | 2 | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid in the cycle rdEn is high |
| txLoad | output | 1 | Transmit buffer write pulse to the transmitter |
| txByte | output | DATA_W | Byte handed to the transmitter |
| txEmptyEv | input | 1 | Transmitter has emptied its buffer |
| rxFullEv | input | 1 | Receiver has loaded a byte |
| rxByte | input | DATA_W | Byte held by the receiver |
| ovrErrEv | input | 1 | Receive overrun detected |
| parErrEv | input | 1 | Receive parity error detected |
| frmErrEv | input | 1 | Receive framing error detected |
| ctsEv | input | 1 | Clear-to-send input changed |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |
| errIrq | output | 1 | Receive error interrupt |
| fcIrq | output | 1 | Flow control interrupt |
| txDmaReq | output | 1 | Transmit DMA request pulse |
| rxDmaReq | output | 1 | Receive DMA request pulse |

## Verification
The assertions check on every cycle that each clearing access drops its interrupt one edge later, unless a set event arrives in that same cycle. They also check that DMA requests never last longer than one cycle, that a request rises only after its event, and that enabling DMA or clearing an enable silences the matching interrupt. The bench scenarios cover what a single cycle cannot show. These are the values that reads return, the set-beats-clear priority, two DMA directions firing together, the status bits for every combination of error sources, and the interrupt outputs for all 64 enable settings with every flag raised.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int EN_W       = 6;
  localparam int ERR_W      = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_TXB  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_RXB  = 2'd3;

  localparam int EN_TXI = 0;
  localparam int EN_RXI = 1;
  localparam int EN_ERI = 2;
  localparam int EN_FCI = 3;
  localparam int EN_TXD = 4;
  localparam int EN_RXD = 5;

  typedef struct packed {
    logic wrCtrl;
    logic wrTx;
    logic rdCtrl;
    logic rdStat;
    logic rdRx;
  } busStrobes_t;

  typedef struct packed {
    logic [EN_W-1:0]  enables;
    logic             ctsChg;
    logic             rxFull;
    logic             txEmpty;
    logic [ERR_W-1:0] errBits;
  } flagView_t;
endpackage

// File: rtl/uirq_busdec.sv
module uirq_busdec
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  flagView_t             view,
  input  logic [DATA_W-1:0]     rxByte,
  output busStrobes_t           strobes,
  output logic [DATA_W-1:0]     rdData
);
  localparam int PAD_W = DATA_W - 8;

  logic [7:0] ctrlWord;
  logic [7:0] statWord;

  always_comb begin
    strobes        = '0;
    strobes.wrCtrl = wrEn && (addr == ADDR_CTRL);
    strobes.wrTx   = wrEn && (addr == ADDR_TXB);
    strobes.rdCtrl = rdEn && (addr == ADDR_CTRL);
    strobes.rdStat = rdEn && (addr == ADDR_STAT);
    strobes.rdRx   = rdEn && (addr == ADDR_RXB);
  end

  assign ctrlWord = {view.ctsChg, 1'b0, view.enables};
  assign statWord = {1'b0, view.ctsChg, view.rxFull, view.txEmpty,
                     |view.errBits, view.errBits};

  generate
    if (PAD_W > 0) begin : g_wide
      always_comb begin
        rdData = '0;
        if (rdEn) begin
          case (addr)
            ADDR_CTRL: rdData = {{PAD_W{1'b0}}, ctrlWord};
            ADDR_STAT: rdData = {{PAD_W{1'b0}}, statWord};
            ADDR_RXB:  rdData = rxByte;
            default:   rdData = '0;
          endcase
        end
      end
    end else begin : g_byte
      always_comb begin
        rdData = '0;
        if (rdEn) begin
          case (addr)
            ADDR_CTRL: rdData = ctrlWord;
            ADDR_STAT: rdData = statWord;
            ADDR_RXB:  rdData = rxByte;
            default:   rdData = '0;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/uirq_flags.sv
module uirq_flags
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEmptyEv,
  input  logic              rxFullEv,
  input  logic [ERR_W-1:0]  errEv,
  input  logic              ctsEv,
  output flagView_t         view,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq,
  output logic              fcIrq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  logic [EN_W-1:0]  enables;
  logic             txEmpty, rxFull, ctsChg;
  logic             txEmptyPrev, rxFullPrev;
  logic [ERR_W-1:0] errBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enables <= '0;
    else if (strobes.wrCtrl) enables <= wrData[EN_W-1:0];
  end

  // A set event in the same cycle as the clearing access wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty     <= 1'b1;
      rxFull      <= 1'b0;
      ctsChg      <= 1'b0;
      txEmptyPrev <= 1'b1;
      rxFullPrev  <= 1'b0;
    end else begin
      txEmpty     <= txEmptyEv | (txEmpty & ~strobes.wrTx);
      rxFull      <= rxFullEv  | (rxFull  & ~strobes.rdRx);
      ctsChg      <= ctsEv     | (ctsChg  & ~strobes.rdCtrl);
      txEmptyPrev <= txEmpty;
      rxFullPrev  <= rxFull;
    end
  end

  generate
    for (genvar i = 0; i < ERR_W; i++) begin : g_err
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) errBits[i] <= 1'b0;
        else       errBits[i] <= errEv[i] | (errBits[i] & ~strobes.rdStat);
      end
    end
  endgenerate

  assign txIrq    = txEmpty & enables[EN_TXI] & ~enables[EN_TXD];
  assign rxIrq    = rxFull  & enables[EN_RXI] & ~enables[EN_RXD];
  assign errIrq   = (|errBits) & enables[EN_ERI];
  assign fcIrq    = ctsChg & enables[EN_FCI];
  assign txDmaReq = enables[EN_TXD] & txEmpty & ~txEmptyPrev;
  assign rxDmaReq = enables[EN_RXD] & rxFull  & ~rxFullPrev;

  assign view.enables = enables;
  assign view.ctsChg  = ctsChg;
  assign view.rxFull  = rxFull;
  assign view.txEmpty = txEmpty;
  assign view.errBits = errBits;
endmodule

// File: rtl/uart_irq_dma_ctl.sv
module uart_irq_dma_ctl
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  txLoad,
  output logic [DATA_W-1:0]     txByte,
  input  logic                  txEmptyEv,
  input  logic                  rxFullEv,
  input  logic [DATA_W-1:0]     rxByte,
  input  logic                  ovrErrEv,
  input  logic                  parErrEv,
  input  logic                  frmErrEv,
  input  logic                  ctsEv,
  output logic                  txIrq,
  output logic                  rxIrq,
  output logic                  errIrq,
  output logic                  fcIrq,
  output logic                  txDmaReq,
  output logic                  rxDmaReq
);
  busStrobes_t strobes;
  flagView_t   view;

  uirq_busdec #(.DATA_W(DATA_W)) u_dec (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .view(view),
    .rxByte(rxByte), .strobes(strobes), .rdData(rdData)
  );

  uirq_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .txEmptyEv(txEmptyEv), .rxFullEv(rxFullEv),
    .errEv({frmErrEv, parErrEv, ovrErrEv}), .ctsEv(ctsEv),
    .view(view), .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq),
    .fcIrq(fcIrq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  assign txLoad = strobes.wrTx;
  assign txByte = wrData;
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [DATA_W-1:0]     wrData,
  input logic                  txEmptyEv,
  input logic                  rxFullEv,
  input logic                  ovrErrEv,
  input logic                  parErrEv,
  input logic                  frmErrEv,
  input logic                  ctsEv,
  input logic                  txIrq,
  input logic                  rxIrq,
  input logic                  errIrq,
  input logic                  fcIrq,
  input logic                  txDmaReq,
  input logic                  rxDmaReq
);
  AST_TXB_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_TXB && !txEmptyEv) |=> (!txIrq && !txDmaReq)); // R2
  AST_RXB_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_RXB && !rxFullEv) |=> (!rxIrq && !rxDmaReq)); // R3
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_STAT && !ovrErrEv && !parErrEv && !frmErrEv) |=> !errIrq); // R4
  AST_CTRL_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_CTRL && !ctsEv) |=> !fcIrq); // R5
  AST_TXDMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |=> !txDmaReq); // R6
  AST_TXDMA_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDmaReq) |-> $past(txEmptyEv)); // R6
  AST_TXDMA_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL && wrData[EN_TXD]) |=> !txIrq); // R6
  AST_RXDMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |=> !rxDmaReq); // R7
  AST_RXDMA_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL && wrData[EN_RXD]) |=> !rxIrq); // R7
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL && !wrData[EN_TXI] && !wrData[EN_FCI]) |=> (!txIrq && !fcIrq)); // R10
endmodule

bind uart_irq_dma_ctl uirq_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_irq_dma_ctl_tb.sv
module uart_irq_dma_ctl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0, rdData, txByte, rxByte = '0;
  logic       txLoad, txEmptyEv = 0, rxFullEv = 0, ovrErrEv = 0, parErrEv = 0;
  logic       frmErrEv = 0, ctsEv = 0;
  logic       txIrq, rxIrq, errIrq, fcIrq, txDmaReq, rxDmaReq;
  logic [7:0] rv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_dma_ctl #(.DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .txLoad(txLoad), .txByte(txByte),
    .txEmptyEv(txEmptyEv), .rxFullEv(rxFullEv), .rxByte(rxByte),
    .ovrErrEv(ovrErrEv), .parErrEv(parErrEv), .frmErrEv(frmErrEv),
    .ctsEv(ctsEv), .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq),
    .fcIrq(fcIrq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    rdEn = 1; addr = a;
    #1 rv = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  // m = {cts, frm, par, ovr, rx, tx}
  task automatic pulse(input logic [5:0] m);
    {ctsEv, frmErrEv, parErrEv, ovrErrEv, rxFullEv, txEmptyEv} = m;
    @(negedge clk);
    {ctsEv, frmErrEv, parErrEv, ovrErrEv, rxFullEv, txEmptyEv} = '0;
  endtask

  task automatic outsLow(input string req);
    chk(req, {txIrq, rxIrq, errIrq, fcIrq, txDmaReq, rxDmaReq}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    outsLow("R1 outputs");
    rd(2'd1); chk("R1 status", rv, 8'h10);
    rd(2'd0); chk("R1 control", rv, 8'h00);

    // R2 transmit interrupt and buffer write
    wr(2'd0, 8'h01); chk("R2 txIrq set", txIrq, 1);
    wrEn = 1; addr = 2'd2; wrData = 8'hA5;
    #1 chk("R2 txLoad", txLoad, 1); chk("R2 txByte", txByte, 8'hA5);
    @(negedge clk); wrEn = 0;
    chk("R2 txIrq cleared", txIrq, 0);
    rd(2'd1); chk("R2 status after write", rv, 8'h00);

    // R6 transmit DMA
    wr(2'd0, 8'h11);
    pulse(6'b000001);
    chk("R6 txDmaReq pulse", txDmaReq, 1); chk("R6 txIrq masked", txIrq, 0);
    @(negedge clk);
    chk("R6 txDmaReq one cycle", txDmaReq, 0);
    wr(2'd0, 8'h01); chk("R6 txIrq after DMA off", txIrq, 1);

    // R3 receive interrupt and buffer read
    wr(2'd0, 8'h02); rxByte = 8'h3C;
    pulse(6'b000010);
    chk("R3 rxIrq set", rxIrq, 1); chk("R3 no rx DMA", rxDmaReq, 0);
    rd(2'd3); chk("R3 rx data", rv, 8'h3C); chk("R3 rxIrq cleared", rxIrq, 0);

    // R7 receive DMA with error interrupt live
    wr(2'd0, 8'h26);
    pulse(6'b000010);
    chk("R7 rxDmaReq pulse", rxDmaReq, 1); chk("R7 rxIrq masked", rxIrq, 0);
    @(negedge clk);
    chk("R7 rxDmaReq one cycle", rxDmaReq, 0);
    pulse(6'b001000);
    chk("R7 errIrq still works", errIrq, 1);
    rd(2'd1); chk("R4 status parity", rv, 8'h3A); chk("R4 errIrq cleared", errIrq, 0);
    rd(2'd3);

    // R8 both DMA directions
    wr(2'd0, 8'h30); wr(2'd2, 8'h00);
    pulse(6'b000011);
    chk("R8 txDmaReq", txDmaReq, 1); chk("R8 rxDmaReq", rxDmaReq, 1);
    @(negedge clk);
    chk("R8 both ended", {txDmaReq, rxDmaReq}, 0);

    // R5 flow control
    wr(2'd0, 8'h08);
    pulse(6'b100000);
    chk("R5 fcIrq set", fcIrq, 1);
    rd(2'd0); chk("R5 control read", rv, 8'h88); chk("R5 fcIrq cleared", fcIrq, 0);
    rd(2'd0); chk("R5 cts flag gone", rv, 8'h08);

    // R9 set wins over clear
    wr(2'd0, 8'h02); chk("R9 rxIrq before", rxIrq, 1);
    rdEn = 1; addr = 2'd3; rxFullEv = 1;
    @(negedge clk); rdEn = 0; rxFullEv = 0;
    chk("R9 rx set wins", rxIrq, 1);
    wr(2'd0, 8'h08);
    rdEn = 1; addr = 2'd0; ctsEv = 1;
    @(negedge clk); rdEn = 0; ctsEv = 0;
    chk("R9 cts set wins", fcIrq, 1);
    wr(2'd0, 8'h04);
    rdEn = 1; addr = 2'd1; ovrErrEv = 1;
    @(negedge clk); rdEn = 0; ovrErrEv = 0;
    chk("R9 error set wins", errIrq, 1);
    rd(2'd1); rd(2'd0);

    // R10 enable off and ignored writes
    wr(2'd0, 8'h02); chk("R10 rxIrq on", rxIrq, 1);
    wr(2'd0, 8'h00); chk("R10 rxIrq off", rxIrq, 0);
    wr(2'd1, 8'hFF); rd(2'd1); chk("R10 status write ignored", rv & 8'h4F, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd0); chk("R10 rx write ignored", rv, 8'h00);

    // R4 sweep over error source combinations
    wr(2'd0, 8'h04);
    for (int e = 1; e < 8; e++) begin
      pulse({2'b00, e[2:0], 1'b0} << 1 >> 1 == 0 ? 6'd0 : {1'b0, e[2:0], 2'b00});
      chk("R4 errIrq", errIrq, 1);
      rd(2'd1); chk("R4 error bits", rv & 8'h0F, {4'b0, 1'b1, e[2:0]});
      chk("R4 cleared irq", errIrq, 0);
      rd(2'd1); chk("R4 cleared bits", rv & 8'h0F, 8'h00);
    end

    // R2 R3 R5 R10 sweep over all enable settings with all flags raised
    pulse(6'b100111);
    for (int en = 0; en < 64; en++) begin
      wr(2'd0, en[7:0]);
      chk("R2 sweep txIrq", txIrq, en[0] & ~en[4]);
      chk("R3 sweep rxIrq", rxIrq, en[1] & ~en[5]);
      chk("R4 sweep errIrq", errIrq, en[2]);
      chk("R5 sweep fcIrq", fcIrq, en[3]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule